// File: doc/BRIEF.md
# Real-Time Clock Change Flag Register

This block is one byte-wide register in a real-time clock's host register file. Its low six bits are change flags. Each flag is raised by a rollover pulse from one stage of the time counters, such as tenths of a second, seconds, minutes, hours, days or months. Each flag drops by itself once the host has read the register. Software can therefore poll the register and learn which parts of the time have moved since its last look, without any write-back step.

Bit 6 means different things for reads and writes. A read returns an oscillator-fail flag. That flag is raised at power-up and on any oscillator failure. It is cleared only by a start command written to the clock's mode register while the crystal is running. A write to bit 6 stores the supply-mode setting: single-supply or battery-backed. A failure event forces that setting back to single-supply.

Bit 7 enables the test-mode register. While bit 7 is clear, the block keeps host accesses to the test register's address from selecting it.

Top module: `rtc_chg_flags`

## Requirements
- R1: A one-cycle pulse on `tick[i]` sets change flag i. The flag appears in `rd_data[i]` on the next read of the register at `FLAG_ADDR` (default 1).
- R2: A read of `FLAG_ADDR` returns the flags as they stood before the read, in `rd_data[5:0]`. All flags are zero from the following cycle, unless R3 applies.
- R3: If `tick[i]` is high in the same cycle as a read of `FLAG_ADDR`, flag i is set after that cycle. The next read returns it.
- R4: Host writes to `FLAG_ADDR` leave flags 5:0 unchanged, whatever `wr_data[5:0]` holds.
- R5: `rd_data[6]` on a read is the oscillator-fail flag. The flag is 1 after reset and is set by `osc_fail_evt`.
- R6: The oscillator-fail flag clears when `start_wr` is high while `xtal_running` is 1. It stays set if `xtal_running` is 0, or if `osc_fail_evt` is high in the same cycle.
- R7: `single_supply` takes `wr_data[6]` on a write to `FLAG_ADDR`. It is 1 after reset and is forced to 1 by `osc_fail_evt`.
- R8: `test_mode_en` takes `wr_data[7]` on a write to `FLAG_ADDR`. It is 0 after reset, and a read returns it in `rd_data[7]`.
- R9: `test_reg_sel` is high only while `test_mode_en` is 1 and a read or write addresses `TEST_ADDR` (0x1F).
- R10: `rd_data` is zero in any cycle without a read of `FLAG_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, acts as power-up |
| bus_addr | input | ADDR_W | Host register address |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| tick | input | N_FLAGS | Rollover pulses from the time counters |
| osc_fail_evt | input | 1 | Oscillator-fail event pulse |
| xtal_running | input | 1 | Crystal is oscillating |
| start_wr | input | 1 | A 1 is being written to the clock start bit |
| rd_data | output | 8 | Read data, combinational during a read |
| single_supply | output | 1 | Supply mode: 1 single-supply, 0 battery-backed |
| test_mode_en | output | 1 | Test register enabled |
| test_reg_sel | output | 1 | Gated select for the test register |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that `tick` and `osc_fail_evt` are held at 0 during reset, so that the first `$past` after reset sees defined values. The bench keeps to these assumptions. Every bus access is a single strobe raised on a falling edge and dropped one cycle later, and all inputs start at zero before reset is released. Collision cases are produced on purpose by driving a rollover pulse in the same cycle as a read, or a fail event in the same cycle as a start write.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  // Next value of one change flag: an event in the clearing cycle wins.
  function automatic logic flag_next(input logic cur, input logic evt, input logic clr);
    return evt | (cur & ~clr);
  endfunction

  // Next oscillator-fail flag: a failure beats a start command.
  function automatic logic osc_fail_next(input logic cur, input logic fail_evt,
                                         input logic start, input logic running);
    if (fail_evt) return 1'b1;
    if (start && running) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/pcf_decode.sv
module pcf_decode #(
  parameter int ADDR_W    = 5,
  parameter int FLAG_ADDR = 1,
  parameter int TEST_ADDR = 31
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              test_en,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic              test_sel
);
  localparam logic [ADDR_W-1:0] FA = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] TA = ADDR_W'(TEST_ADDR);

  always_comb begin
    rd_hit   = rd && (addr == FA);
    wr_hit   = wr && (addr == TA ? 1'b0 : addr == FA);
    test_sel = test_en && (rd || wr) && (addr == TA);
  end
endmodule

// File: rtl/pcf_flag_bank.sv
module pcf_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] flags
);
  import pcf_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flag_next(flags[i], evt[i], clr);
    end
  end
endmodule

// File: rtl/pcf_osc_ctl.sv
module pcf_osc_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_evt,
  input  logic start_wr,
  input  logic xtal_running,
  input  logic wr_hit,
  input  logic wr_supply,
  input  logic wr_test,
  output logic osc_fail,
  output logic single_supply,
  output logic test_en
);
  import pcf_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_fail      <= 1'b1;
      single_supply <= 1'b1;
      test_en       <= 1'b0;
    end else begin
      osc_fail <= osc_fail_next(osc_fail, fail_evt, start_wr, xtal_running);
      if (fail_evt)    single_supply <= 1'b1;
      else if (wr_hit) single_supply <= wr_supply;
      if (wr_hit)      test_en <= wr_test;
    end
  end
endmodule

// File: rtl/rtc_chg_flags.sv
module rtc_chg_flags #(
  parameter int ADDR_W    = 5,
  parameter int N_FLAGS   = 6,
  parameter int FLAG_ADDR = 1,
  parameter int TEST_ADDR = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [N_FLAGS+1:0]   wr_data,
  input  logic [N_FLAGS-1:0]   tick,
  input  logic                 osc_fail_evt,
  input  logic                 xtal_running,
  input  logic                 start_wr,
  output logic [N_FLAGS+1:0]   rd_data,
  output logic                 single_supply,
  output logic                 test_mode_en,
  output logic                 test_reg_sel
);
  localparam int DATA_W   = N_FLAGS + 2;
  localparam int OSC_BIT  = N_FLAGS;
  localparam int TEST_BIT = N_FLAGS + 1;

  // Named internal events, visible to the bound checker.
  logic               rd_hit;
  logic               wr_hit;
  logic [N_FLAGS-1:0] flag_q;
  logic               osc_fail_q;

  pcf_decode #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .TEST_ADDR(TEST_ADDR)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .test_en(test_mode_en),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .test_sel(test_reg_sel)
  );

  pcf_flag_bank #(.N(N_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(tick), .clr(rd_hit), .flags(flag_q)
  );

  pcf_osc_ctl u_osc (
    .clk(clk), .rst_n(rst_n), .fail_evt(osc_fail_evt), .start_wr(start_wr),
    .xtal_running(xtal_running), .wr_hit(wr_hit),
    .wr_supply(wr_data[OSC_BIT]), .wr_test(wr_data[TEST_BIT]),
    .osc_fail(osc_fail_q), .single_supply(single_supply), .test_en(test_mode_en)
  );

  // Read data shows the pre-clear state; the clear lands at the clock edge.
  always_comb begin
    rd_data = '0;
    if (rd_hit) rd_data = {test_mode_en, osc_fail_q, flag_q};
  end
endmodule

// File: rtl/rtc_chg_flags_chk.sv
module rtc_chg_flags_chk #(
  parameter int N_FLAGS = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_hit,
  input logic [N_FLAGS-1:0] tick,
  input logic [N_FLAGS-1:0] flag_q,
  input logic               osc_fail_q,
  input logic               osc_fail_evt,
  input logic               start_wr,
  input logic               xtal_running,
  input logic               single_supply,
  input logic               test_mode_en,
  input logic               test_reg_sel
);
  // R1
  tick_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tick) |=> ((flag_q & $past(tick)) == $past(tick)));
  // R2
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> ((flag_q & ~$past(tick)) == '0));
  // R3
  collide_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && |tick) |=> (flag_q != '0));
  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> (flag_q == ($past(flag_q) | $past(tick))));
  // R5
  fail_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail_evt |=> osc_fail_q);
  // R6
  fail_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_fail_q) |-> $past(start_wr && xtal_running));
  // R7
  supply_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail_evt |=> single_supply);
  // R9
  test_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_reg_sel |-> test_mode_en);
endmodule

bind rtc_chg_flags rtc_chg_flags_chk #(.N_FLAGS(N_FLAGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .tick(tick), .flag_q(flag_q),
  .osc_fail_q(osc_fail_q), .osc_fail_evt(osc_fail_evt), .start_wr(start_wr),
  .xtal_running(xtal_running), .single_supply(single_supply),
  .test_mode_en(test_mode_en), .test_reg_sel(test_reg_sel)
);

// File: tb/tb_rtc_chg_flags.sv
module tb_rtc_chg_flags;
  localparam int FA = 1;
  localparam int TA = 31;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [5:0] tick = '0;
  logic       osc_fail_evt = 1'b0, xtal_running = 1'b0, start_wr = 1'b0;
  logic [7:0] rd_data;
  logic       single_supply, test_mode_en, test_reg_sel;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_chg_flags dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .wr_data(wr_data), .tick(tick), .osc_fail_evt(osc_fail_evt),
    .xtal_running(xtal_running), .start_wr(start_wr), .rd_data(rd_data),
    .single_supply(single_supply), .test_mode_en(test_mode_en),
    .test_reg_sel(test_reg_sel)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [4:0] a, input logic [5:0] tk, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; tick = tk;
    #1 d = rd_data;
    @(negedge clk);
    bus_rd = 1'b0; tick = '0;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; wr_data = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_tick(input logic [5:0] v);
    @(negedge clk); tick = v;
    @(negedge clk); tick = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R7 reset supply", {7'd0, single_supply}, 8'd1);
    check("R8 reset test", {7'd0, test_mode_en}, 8'd0);
    check("R10 idle rd_data", rd_data, 8'h00);
    rd_reg(5'(FA), 6'd0, d);
    check("R5 reset read", d, 8'h40);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    pulse_tick(6'b000101);
    rd_reg(5'(FA), 6'd0, d);
    check("R1 flags 0,2", d, 8'h45);
    rd_reg(5'(FA), 6'd0, d);
    check("R2 cleared", d, 8'h40);
    pulse_tick(6'b111111);
    rd_reg(5'(FA), 6'd0, d);
    check("R1 all flags", d, 8'h7F);
    rd_reg(5'(FA), 6'd0, d);
    check("R2 cleared all", d, 8'h40);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pulse_tick(6'b000010);
    rd_reg(5'(FA), 6'b100010, d);
    check("R2 pre-clear value", d, 8'h42);
    rd_reg(5'(FA), 6'd0, d);
    check("R3 collide kept", d, 8'h62);
    rd_reg(5'(FA), 6'd0, d);
    check("R3 then cleared", d, 8'h40);
  endtask

  task automatic t_write();
    logic [7:0] d;
    pulse_tick(6'b000011);
    wr_reg(5'(FA), 8'h00);
    check("R7 supply written 0", {7'd0, single_supply}, 8'd0);
    rd_reg(5'(FA), 6'd0, d);
    check("R4 write kept flags", d, 8'h43);
    wr_reg(5'(FA), 8'h3F);
    rd_reg(5'(FA), 6'd0, d);
    check("R4 write set none", d, 8'h40);
    wr_reg(5'(FA), 8'h40);
    check("R7 supply written 1", {7'd0, single_supply}, 8'd1);
  endtask

  task automatic t_osc();
    logic [7:0] d;
    wr_reg(5'(FA), 8'h00);
    @(negedge clk); start_wr = 1'b1; xtal_running = 1'b0;
    @(negedge clk); start_wr = 1'b0;
    rd_reg(5'(FA), 6'd0, d);
    check("R6 no clear when stopped", d, 8'h40);
    @(negedge clk); start_wr = 1'b1; xtal_running = 1'b1;
    @(negedge clk); start_wr = 1'b0;
    rd_reg(5'(FA), 6'd0, d);
    check("R6 cleared by start", d, 8'h00);
    @(negedge clk); osc_fail_evt = 1'b1;
    @(negedge clk); osc_fail_evt = 1'b0;
    check("R7 fail forces supply", {7'd0, single_supply}, 8'd1);
    rd_reg(5'(FA), 6'd0, d);
    check("R5 fail event sets", d, 8'h40);
    @(negedge clk); osc_fail_evt = 1'b1; start_wr = 1'b1;
    @(negedge clk); osc_fail_evt = 1'b0; start_wr = 1'b0;
    rd_reg(5'(FA), 6'd0, d);
    check("R6 fail beats start", d, 8'h40);
    @(negedge clk); start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
    rd_reg(5'(FA), 6'd0, d);
    check("R6 cleared again", d, 8'h00);
  endtask

  task automatic t_test();
    logic [7:0] d;
    @(negedge clk); bus_addr = 5'(TA); bus_rd = 1'b1;
    #1 check("R9 gated off", {7'd0, test_reg_sel}, 8'd0);
    @(negedge clk); bus_rd = 1'b0;
    wr_reg(5'(FA), 8'h80);
    check("R8 test enabled", {7'd0, test_mode_en}, 8'd1);
    rd_reg(5'(FA), 6'd0, d);
    check("R8 readback", d, 8'h80);
    @(negedge clk); bus_addr = 5'(TA); bus_wr = 1'b1;
    #1 check("R9 selected", {7'd0, test_reg_sel}, 8'd1);
    check("R10 other addr rd_data", rd_data, 8'h00);
    @(negedge clk); bus_wr = 1'b0;
    #1 check("R9 no strobe", {7'd0, test_reg_sel}, 8'd0);
    @(negedge clk); bus_addr = 5'd2; bus_rd = 1'b1;
    #1 check("R9 wrong addr", {7'd0, test_reg_sel}, 8'd0);
    check("R10 read of other addr", rd_data, 8'h00);
    @(negedge clk); bus_rd = 1'b0;
    wr_reg(5'(FA), 8'h00);
    check("R8 test disabled", {7'd0, test_mode_en}, 8'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_flags();
    t_collide();
    t_write();
    t_osc();
    t_test();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule